// File: doc/BRIEF.md
# Fuse Span Reader

This block fetches an arbitrary run of bytes from a one-time-programmable fuse array whose read port only delivers aligned 32-bit words. A requester gives a byte offset and a byte count with a single-cycle start. The block widens that range to whole words, reads each word in turn by driving the array's control and address lines with a timed strobe, and returns exactly the requested bytes, in ascending address order, on a valid/ready byte stream.

Every hold time in the read sequence is one microsecond, expressed as `CLK_MHZ` clock cycles. Before the first word the array is put into read mode for that time. Each word is then strobed, with its address applied in the same cycle as the strobe. After the last word the array returns to its low-power standby pattern, and a one-cycle done pulse is raised. The sequencer never strobes a new word while a byte of the current word is still waiting at the output. Programming the array, clock gating and software registers are outside this block.

Top module: `fuse_span_reader`

## Requirements
- R1: The control word `fuse_ctrl_o` places chip-select-bar on bit 0, strobe on bit 1, load on bit 2, program-enable-bar on bit 3, power-down on bit 5, read-sense-bar on bit 7 and strobe-shift-select on bit 9. The word address occupies bits 25:16, and every other bit is 0.
- R2: After reset, and whenever the block is idle, `fuse_ctrl_o` equals 0x21 (power-down and chip-select-bar only), `byte_valid_o` is 0 and `busy_o` is 0.
- R3: An accepted start first drives the read-mode pattern 0x28C (load, program-enable-bar, read-sense-bar and strobe-shift-select, address 0, strobe low) for exactly `CLK_MHZ` cycles before the first strobe.
- R4: The number of words read is ceil((offset+length)/4) - floor(offset/4). The first address is floor(offset/4), and each later word uses the previous address plus one, wrapping modulo 1024.
- R5: The strobe rises in the same cycle its address appears. It stays high for exactly `CLK_MHZ` cycles with the address unchanged, and data is sampled in its last high cycle. Consecutive strobes are separated by at least `CLK_MHZ` low cycles.
- R6: Bytes leave least significant byte first. The first offset mod 4 bytes of the first word are dropped. Exactly `length` bytes are delivered, each equal to the array byte at offset+k, and any trailing bytes of the last word are discarded.
- R7: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` and `byte_o` hold their values into the next cycle.
- R8: A strobe never rises while `byte_valid_o` is high.
- R9: Once all words are read and all requested bytes are accepted, the block drives the standby pattern 0x21 and raises `done_o` for exactly one cycle in that same cycle, then returns to idle.
- R10: A start while `busy_o` is high is ignored, and the running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| offset_i | input | ADDR_W+2 (12) | Byte offset of the first byte |
| length_i | input | ADDR_W+3 (13) | Number of bytes to deliver |
| busy_o | output | 1 | High from the accepted start until the done cycle |
| done_o | output | 1 | One-cycle pulse when standby is driven after a request |
| fuse_ctrl_o | output | 32 | Control and address word to the fuse array |
| fuse_dout_i | input | 32 | Word returned by the fuse array |
| byte_o | output | 8 | Output byte |
| byte_valid_o | output | 1 | Output byte is valid |
| byte_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The bound checker looks at every cycle for rules that hold instant by instant. The control word is standby whenever the block is idle or done. The bits around a raised strobe are fixed and the address stays put while the strobe is high. No strobe starts with a byte pending, an unaccepted byte is held, and done lasts one cycle. Only the bench's request sweeps can show the arithmetic: how many words a range needs, the address wrap, which head and tail bytes are dropped, and the byte values. The bench also measures the exact lengths of the read-mode and strobe intervals, under both continuous and throttled acceptance and with a start issued mid-request.

// File: rtl/fsr_pkg.sv
// Package: shared control-word layout and sequencer state encoding for the
// fuse span reader. Assumes a 32-bit control word with a 10-bit address field.
package fsr_pkg;

    localparam int CTRL_W    = 32;
    localparam int BIT_CSB   = 0;
    localparam int BIT_STB   = 1;
    localparam int BIT_LOAD  = 2;
    localparam int BIT_PGENB = 3;
    localparam int BIT_PD    = 5;
    localparam int BIT_RSB   = 7;
    localparam int BIT_SSEL  = 9;
    localparam int ADDR_LSB  = 16;

    // Standby: power-down and chip-select-bar high, everything else low.
    localparam logic [CTRL_W-1:0] CTRL_STANDBY =
        (32'd1 << BIT_PD) | (32'd1 << BIT_CSB);

    // Read mode: load, program-enable-bar, read-sense-bar, strobe-shift-select.
    localparam logic [CTRL_W-1:0] CTRL_READ =
        (32'd1 << BIT_LOAD) | (32'd1 << BIT_PGENB) |
        (32'd1 << BIT_RSB)  | (32'd1 << BIT_SSEL);

    localparam logic [CTRL_W-1:0] CTRL_STROBE = 32'd1 << BIT_STB;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_RELEASE,
        SQ_FINISH
    } seq_state_t;

endpackage

// File: rtl/fsr_span.sv
// Module: fsr_span
// Converts a byte offset and byte length into a whole-word range: first word
// index, number of words to read and the count of leading bytes to drop.
// Purely combinational; assumes 4-byte words.
module fsr_span #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = ADDR_W + 2,
    parameter int LEN_W  = BYTE_W + 1
) (
    input  logic [BYTE_W-1:0] offset_i,
    input  logic [LEN_W-1:0]  length_i,
    output logic [ADDR_W-1:0] first_word_o,
    output logic [BYTE_W-1:0] word_count_o,
    output logic [1:0]        head_skip_o
);

    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0]  sum_end;
    logic [BYTE_W-1:0] end_idx;

    // Exclusive end byte rounded up to the next word boundary.
    always_comb begin
        sum_end = SUM_W'(offset_i) + SUM_W'(length_i) + SUM_W'(3);
        end_idx = sum_end[SUM_W-1:2];
    end

    // Word range and head trim derived from the offset.
    always_comb begin
        first_word_o = offset_i[BYTE_W-1:2];
        word_count_o = end_idx - BYTE_W'(first_word_o);
        head_skip_o  = offset_i[1:0];
    end

endmodule

// File: rtl/fsr_unpacker.sv
// Module: fsr_unpacker
// Holds one sampled 32-bit word and emits its bytes least significant first
// on a valid/ready port. The first word after arming starts at the head-skip
// lane; a byte budget stops output after the requested count, discarding any
// lanes left in the word. Assumes load never coincides with a pending byte.
module fsr_unpacker #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [LEN_W-1:0] arm_len_i,
    input  logic [1:0]       arm_skip_i,
    input  logic             load_i,
    input  logic [31:0]      word_i,
    input  logic             ready_i,
    output logic [7:0]       byte_o,
    output logic             valid_o,
    output logic             empty_o
);

    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic [1:0]       skip_q;
    logic [LEN_W-1:0] remain_q;
    logic             first_q;
    logic             have_q;

    // Arm the budget, capture a word, or step to the next lane on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            lane_q   <= '0;
            skip_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
            have_q   <= 1'b0;
        end else if (arm_i) begin
            remain_q <= arm_len_i;
            skip_q   <= arm_skip_i;
            first_q  <= 1'b1;
            have_q   <= 1'b0;
        end else if (load_i) begin
            word_q  <= word_i;
            lane_q  <= first_q ? skip_q : 2'd0;
            first_q <= 1'b0;
            have_q  <= (remain_q != '0);
        end else if (have_q && ready_i) begin
            remain_q <= remain_q - LEN_W'(1);
            lane_q   <= lane_q + 2'd1;
            if (lane_q == 2'd3 || remain_q == LEN_W'(1)) begin
                have_q <= 1'b0;
            end
        end
    end

    // Present the current lane.
    always_comb begin
        byte_o  = word_q[{lane_q, 3'b000} +: 8];
        valid_o = have_q;
        empty_o = !have_q;
    end

endmodule

// File: rtl/fsr_sequencer.sv
// Module: fsr_sequencer
// Drives the fuse control word through read-mode setup, one strobe per word
// and the return to standby. Each hold is WAIT_CYC cycles. A new strobe is
// only issued once the byte buffer is empty. Assumes ADDR_W <= 16.
module fsr_sequencer
    import fsr_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int WCNT_W   = 12,
    parameter int WAIT_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] first_word_i,
    input  logic [WCNT_W-1:0] word_count_i,
    input  logic              buf_empty_i,
    output logic              sample_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WCNT_W-1:0] left_q;
    logic              wait_done;

    // End of the current one-microsecond hold.
    always_comb wait_done = (cnt_q == WAIT_LAST);

    // State, hold counter, word address and remaining-word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (go_i) begin
                        addr_q  <= first_word_i;
                        left_q  <= word_count_i;
                        cnt_q   <= '0;
                        state_q <= SQ_SETUP;
                    end
                end
                SQ_SETUP: begin
                    if (wait_done) begin
                        cnt_q   <= '0;
                        state_q <= (left_q == '0) ? SQ_FINISH : SQ_STROBE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SQ_STROBE: begin
                    if (wait_done) begin
                        cnt_q   <= '0;
                        state_q <= SQ_RELEASE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SQ_RELEASE: begin
                    if (!wait_done) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end else if (buf_empty_i) begin
                        cnt_q   <= '0;
                        addr_q  <= addr_q + ADDR_W'(1);
                        left_q  <= left_q - WCNT_W'(1);
                        state_q <= (left_q == WCNT_W'(1)) ? SQ_FINISH : SQ_STROBE;
                    end
                end
                SQ_FINISH: begin
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Control word, sample strobe and status decoded from the state.
    always_comb begin
        ctrl_o = CTRL_STANDBY;
        case (state_q)
            SQ_SETUP:   ctrl_o = CTRL_READ;
            SQ_STROBE: begin
                ctrl_o = CTRL_READ | CTRL_STROBE;
                ctrl_o[ADDR_LSB +: ADDR_W] = addr_q;
            end
            SQ_RELEASE: begin
                ctrl_o = CTRL_READ;
                ctrl_o[ADDR_LSB +: ADDR_W] = addr_q;
            end
            default:    ctrl_o = CTRL_STANDBY;
        endcase
        sample_o = (state_q == SQ_STROBE) && wait_done;
        done_o   = (state_q == SQ_FINISH);
        busy_o   = (state_q != SQ_IDLE);
    end

endmodule

// File: rtl/fuse_span_reader.sv
// Module: fuse_span_reader (top)
// Reads an arbitrary byte range from a word-organised fuse array and streams
// the bytes out in address order. CLK_MHZ sets the cycles per microsecond
// hold. Starts arriving while busy are ignored.
module fuse_span_reader
    import fsr_pkg::*;
#(
    parameter int CLK_MHZ = 100,
    parameter int ADDR_W  = 10,
    localparam int BYTE_W = ADDR_W + 2,
    localparam int LEN_W  = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] offset_i,
    input  logic [LEN_W-1:0]  length_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [31:0]       fuse_ctrl_o,
    input  logic [31:0]       fuse_dout_i,
    output logic [7:0]        byte_o,
    output logic              byte_valid_o,
    input  logic              byte_ready_i
);

    logic [ADDR_W-1:0] first_word;
    logic [BYTE_W-1:0] word_count;
    logic [1:0]        head_skip;
    logic              go;
    logic              sample;
    logic              buf_empty;

    // A start is only taken while idle.
    always_comb go = start_i && !busy_o;

    fsr_span #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LEN_W  (LEN_W)
    ) u_span (
        .offset_i     (offset_i),
        .length_i     (length_i),
        .first_word_o (first_word),
        .word_count_o (word_count),
        .head_skip_o  (head_skip)
    );

    fsr_sequencer #(
        .ADDR_W   (ADDR_W),
        .WCNT_W   (BYTE_W),
        .WAIT_CYC (CLK_MHZ)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go),
        .first_word_i (first_word),
        .word_count_i (word_count),
        .buf_empty_i  (buf_empty),
        .sample_o     (sample),
        .done_o       (done_o),
        .busy_o       (busy_o),
        .ctrl_o       (fuse_ctrl_o)
    );

    fsr_unpacker #(
        .LEN_W (LEN_W)
    ) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (go),
        .arm_len_i  (length_i),
        .arm_skip_i (head_skip),
        .load_i     (sample),
        .word_i     (fuse_dout_i),
        .ready_i    (byte_ready_i),
        .byte_o     (byte_o),
        .valid_o    (byte_valid_o),
        .empty_o    (buf_empty)
    );

endmodule

// File: rtl/fsr_checker.sv
// Module: fsr_checker
// Cycle-by-cycle protocol rules for fuse_span_reader, attached by bind.
// Observes ports only.
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [31:0] ctrl,
    input logic [7:0]  bdata,
    input logic        bvalid,
    input logic        bready
);

    localparam logic [31:0] ADDR_FIELD = ((32'd1 << ADDR_W) - 32'd1) << ADDR_LSB;

    // R2: idle means the standby pattern on the control word.
    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ctrl == CTRL_STANDBY);

    // R1: while strobing, the non-address bits are read mode plus strobe.
    assert_strobe_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[BIT_STB] |-> (ctrl & ~ADDR_FIELD) == (CTRL_READ | CTRL_STROBE));

    // R5: address stays fixed while the strobe is held high.
    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[BIT_STB] && $past(ctrl[BIT_STB]) |-> $stable(ctrl & ADDR_FIELD));

    // R8: no strobe begins while a byte is pending.
    assert_no_strobe_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[BIT_STB]) |-> !bvalid);

    // R7: an unaccepted byte is held.
    assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid && $stable(bdata));

    // R9: done coincides with standby and lasts one cycle.
    assert_done_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ctrl == CTRL_STANDBY);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind fuse_span_reader fsr_checker #(.ADDR_W(ADDR_W)) u_fsr_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy_o),
    .done   (done_o),
    .ctrl   (fuse_ctrl_o),
    .bdata  (byte_o),
    .bvalid (byte_valid_o),
    .bready (byte_ready_i)
);

// File: tb/tb_fuse_span_reader.sv
module tb_fuse_span_reader;

    localparam int W        = 3;
    localparam int STANDBY  = 32'h21;
    localparam int READPAT  = 32'h28C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] offset_in = '0;
    logic [12:0] length_in = '0;
    logic        busy, done;
    logic [31:0] fuse_ctrl;
    logic [31:0] fuse_dout;
    logic [7:0]  byte_data;
    logic        byte_valid;
    logic        byte_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    fuse_span_reader #(.CLK_MHZ(W), .ADDR_W(10)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .offset_i     (offset_in),
        .length_i     (length_in),
        .busy_o       (busy),
        .done_o       (done),
        .fuse_ctrl_o  (fuse_ctrl),
        .fuse_dout_i  (fuse_dout),
        .byte_o       (byte_data),
        .byte_valid_o (byte_valid),
        .byte_ready_i (byte_ready)
    );

    // Fuse array model: content is a function of the word address.
    function automatic logic [31:0] fuse_word(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b * 8'd3 + 8'd1, b + 8'h40, b ^ 8'hC3, b * 8'd5 + 8'd7};
    endfunction

    assign fuse_dout = fuse_word(int'(fuse_ctrl[25:16]));

    function automatic logic [7:0] exp_byte(input int off, input int k);
        int ba;
        logic [31:0] w;
        ba = off + k;
        w  = fuse_word((ba >> 2) & 1023);
        return w[(ba & 3) * 8 +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One request; mode 0 = always ready, mode 1 = ready every third cycle.
    task automatic run_case(input int off, input int len, input int mode, input bit poke);
        int first, exp_words, got, cyc, strobes, setup_cyc, hi_len, lo_len, dones;
        int addr_bad, bits_bad, pend_bad, gap_bad, hi_bad, hold_bad, data_bad, done_bad;
        bit prev_stb, seen, finished, prev_valid, prev_ready, rdy;
        logic [7:0] prev_byte;
        first = off >> 2;
        exp_words = ((off + len + 3) >> 2) - first;
        got = 0; cyc = 0; strobes = 0; setup_cyc = 0; hi_len = 0; lo_len = 0; dones = 0;
        addr_bad = 0; bits_bad = 0; pend_bad = 0; gap_bad = 0; hi_bad = 0;
        hold_bad = 0; data_bad = 0; done_bad = 0;
        prev_stb = 0; seen = 0; finished = 0; prev_valid = 0; prev_ready = 0;
        prev_byte = '0;
        @(negedge clk);
        start = 1'b1; offset_in = 12'(off); length_in = 13'(len);
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            // R10: a second start with different values mid-request.
            if (poke && cyc == 4) begin
                start = 1'b1; offset_in = 12'(off + 5); length_in = 13'(len + 3);
            end else begin
                start = 1'b0;
            end
            if (fuse_ctrl[1]) begin
                if (!prev_stb) begin
                    strobes++;
                    if (int'(fuse_ctrl[25:16]) != ((first + strobes - 1) & 1023)) addr_bad++;
                    if ((fuse_ctrl & 32'hFC00_FFFF) != (READPAT | 2)) bits_bad++;
                    if (byte_valid) pend_bad++;
                    if (seen && lo_len < W) gap_bad++;
                    seen = 1; hi_len = 0;
                end
                hi_len++;
            end else begin
                if (prev_stb) begin
                    if (hi_len != W) hi_bad++;
                    lo_len = 0;
                end
                lo_len++;
                if (!seen && busy && fuse_ctrl == READPAT) setup_cyc++;
            end
            if (prev_valid && !prev_ready && (!byte_valid || byte_data != prev_byte)) hold_bad++;
            if (done) begin
                dones++;
                if (fuse_ctrl != STANDBY) done_bad++;
                if (got != len) done_bad++;
                finished = 1;
            end
            rdy = (mode == 0) ? 1'b1 : (cyc % 3 == 0);
            byte_ready = rdy;
            if (byte_valid && rdy) begin
                if (got >= len || byte_data != exp_byte(off, got)) data_bad++;
                got++;
            end
            prev_stb = fuse_ctrl[1]; prev_valid = byte_valid;
            prev_ready = rdy; prev_byte = byte_data;
        end
        @(negedge clk);
        byte_ready = 1'b0;
        check(finished, "R9", "request completed", cyc, 0);
        check(strobes == exp_words, "R4", "words strobed", strobes, exp_words);
        check(addr_bad == 0, "R4", "word address sequence errors", addr_bad, 0);
        check(bits_bad == 0, "R1", "control bits during strobe", bits_bad, 0);
        check(setup_cyc == W, "R3", "read-mode setup cycles", setup_cyc, W);
        check(hi_bad == 0 && gap_bad == 0, "R5", "strobe high/low timing errors",
              hi_bad + gap_bad, 0);
        check(pend_bad == 0, "R8", "strobe with byte pending", pend_bad, 0);
        check(hold_bad == 0, "R7", "held byte changed", hold_bad, 0);
        check(got == len, "R6", "bytes delivered", got, len);
        check(data_bad == 0, (poke ? "R10" : "R6"), "byte value errors", data_bad, 0);
        check(dones == 1 && done_bad == 0, "R9", "done pulse / standby at done",
              dones * 100 + done_bad, 100);
        check(!busy && fuse_ctrl == STANDBY && !done && !byte_valid, "R2",
              "idle after request", int'(fuse_ctrl), STANDBY);
    endtask

    // Global watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired: actual=190000 expected=<190000 cycles");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state.
        check(fuse_ctrl == STANDBY, "R2", "control word in reset", int'(fuse_ctrl), STANDBY);
        rst_n = 1'b1;
        @(negedge clk);
        check(fuse_ctrl == STANDBY && !busy && !byte_valid && !done, "R2",
              "idle after reset", int'(fuse_ctrl), STANDBY);
        // Near-exhaustive sweep over head alignment and length.
        for (int m = 0; m < 2; m++)
            for (int o = 0; o < 8; o++)
                for (int l = 0; l < 10; l++)
                    run_case(o, l, m, 1'b0);
        // R4: address wrap across the end of the array.
        run_case(4090, 10, 0, 1'b0);
        run_case(4093, 7, 1, 1'b0);
        // Long unaligned span under backpressure.
        run_case(3, 40, 1, 1'b0);
        // R10: start while busy is ignored.
        run_case(2, 7, 0, 1'b1);
        run_case(5, 9, 1, 1'b1);
        finish_run();
    end

endmodule